// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block decides whether a selector may be placed in one segment register of a protected-mode segmented processor. It takes the selector, the register class it is meant for, the current privilege level, both descriptor-table limits and the fields of a descriptor that was already fetched. From these it either reports a fault, with its exception vector and error code, or returns the expanded segment: base, byte-granular limit and a packed access word.

The caller places one request on the inputs and raises `in_valid` for a cycle. One cycle later `out_valid` pulses with the verdict. The checks run in a fixed order: table indicator, table limit, null selector, type, present, privilege. Only the first failing check is reported. Fetching the descriptor from memory is the caller's job.

Register classes on `reg_class`: 0 is the local-table register, 1 is code, 2 is stack and 3 is data. Vector codes: 10 is invalid task state, 11 is segment not present and 12 is stack fault.

Top module: `seg_load_check`

## Requirements
- R1: Each cycle with `in_valid` high is followed, in the next cycle, by exactly one cycle of `out_valid` high. No other cycle has `out_valid` high.
- R2: For the local-table class, a selector with bit 2 set faults with vector 10.
- R3: The selected table is the local table when selector bit 2 is 1 and the global table otherwise. The load faults with vector 10 when that table's limit is below (selector OR 7). It also faults with vector 10 when the local table is selected and `ldt_ok` is 0.
- R4: A selector whose bits 15:3 are all zero faults with vector 10 for the code and stack classes. For the other classes it passes with base 0, limit 0 and access 0x10000.
- R5: The 5-bit type must match the class, otherwise the load faults with vector 10:
  - code: (t & 0x18) == 0x18
  - stack: (t & 0x1A) == 0x12
  - data: (t & 0x18) == 0x10, or (t & 0x1A) == 0x1A
  - local-table register: t == 0x02
- R6: If the present flag is clear, the vector is 10 for the local-table class, 12 for stack and 11 for code and data.
- R7: Stack loads fault with vector 10 unless RPL (selector bits 1:0) and DPL both equal CPL.
- R8: Code loads fault with vector 10 when a conforming segment (type bit 2 set) has CPL < DPL, or when a non-conforming one has CPL != DPL.
- R9: Data loads fault with vector 10 when RPL > DPL or CPL > DPL. The one exception is a descriptor that is conforming code (type bits 4:3 = 11 and bit 2 = 1), which skips this check.
- R10: On a fault the error code is {selector[15:2], 0, ext}. On a pass the error code and vector are 0, and base, limit and access are 0 on a fault.
- R11: The expanded limit is {raw_limit, 0xFFF} when the granularity flag is set, and the zero-extended 20-bit raw limit otherwise.
- R12: Access word: type in bits 4:0, DPL in 6:5, present in 7, AVL in 12, D/B in 14, granularity in 15, unusable in 16. All other bits are 0.
- R13: When several checks fail, the fault reported is the first one in the order table indicator, limit, null, type, present, privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| reg_class | input | 2 | Target register class |
| selector | input | 16 | Selector being loaded |
| cpl | input | 2 | Current privilege level |
| gdt_limit | input | 32 | Global table limit |
| ldt_limit | input | 32 | Local table limit |
| ldt_ok | input | 1 | Local table usable and present |
| desc_type | input | 5 | Descriptor type including the S bit |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present flag |
| desc_avl | input | 1 | Software-available flag |
| desc_db | input | 1 | Default size flag |
| desc_gran | input | 1 | Granularity flag |
| desc_limit | input | 20 | Raw limit |
| desc_base | input | 32 | Base address |
| ext | input | 1 | External-event flag for the error code |
| out_valid | output | 1 | Result strobe |
| fault | output | 1 | Load refused |
| vector | output | 8 | Exception vector (0 on pass) |
| err_code | output | 16 | Error code (0 on pass) |
| seg_base | output | 32 | Expanded base |
| seg_limit | output | 32 | Expanded limit |
| seg_access | output | 17 | Packed access word |

## Verification
The bench targets the limit boundary where the table limit equals selector OR 7. A design using the wrong comparison would refuse that legal load. It checks that a null selector with RPL bits set still yields a zero error code, and that a null data load gives the unusable marker instead of a fault. Not-present descriptors are tried in every class, because a mixed-up vector table would report a stack fault on a code load. Cases that fail two checks at once expose a reordered chain; for example, a stack descriptor of the wrong type that is also absent must report vector 10, not 12. Conforming code used as data probes the privilege exemption, which a design that treats all data as non-conforming would refuse.

// File: rtl/seg_load_check.sv
module seg_load_check #(
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    reg_class,
  input  logic [15:0]   selector,
  input  logic [1:0]    cpl,
  input  logic [LW-1:0] gdt_limit,
  input  logic [LW-1:0] ldt_limit,
  input  logic          ldt_ok,
  input  logic [4:0]    desc_type,
  input  logic [1:0]    desc_dpl,
  input  logic          desc_present,
  input  logic          desc_avl,
  input  logic          desc_db,
  input  logic          desc_gran,
  input  logic [19:0]   desc_limit,
  input  logic [31:0]   desc_base,
  input  logic          ext,
  output logic          out_valid,
  output logic          fault,
  output logic [7:0]    vector,
  output logic [15:0]   err_code,
  output logic [31:0]   seg_base,
  output logic [31:0]   seg_limit,
  output logic [16:0]   seg_access
);
  localparam logic [1:0] C_LDT = 2'd0, C_CODE = 2'd1, C_STACK = 2'd2, C_DATA = 2'd3;
  localparam logic [7:0] V_TS = 8'd10, V_NP = 8'd11, V_SS = 8'd12;

  logic [1:0]    rpl;
  logic          ti, is_null, lim_bad, type_ok, conf, priv_bad;
  logic [LW-1:0] tbl_lim, sel_end;
  logic          f_d;
  logic [7:0]    v_d;

  assign rpl     = selector[1:0];
  assign ti      = selector[2];
  assign is_null = (selector[15:3] == 13'd0);
  assign tbl_lim = ti ? ldt_limit : gdt_limit;
  assign sel_end = LW'(selector | 16'h0007);
  assign lim_bad = (tbl_lim < sel_end) || (ti && !ldt_ok);
  assign conf    = desc_type[2];

  always_comb begin
    case (reg_class)
      C_LDT:   type_ok = (desc_type == 5'h02);
      C_CODE:  type_ok = ((desc_type & 5'h18) == 5'h18);
      C_STACK: type_ok = ((desc_type & 5'h1A) == 5'h12);
      default: type_ok = ((desc_type & 5'h18) == 5'h10) || ((desc_type & 5'h1A) == 5'h1A);
    endcase
  end

  always_comb begin
    case (reg_class)
      C_CODE:  priv_bad = conf ? (cpl < desc_dpl) : (cpl != desc_dpl);
      C_STACK: priv_bad = (rpl != cpl) || (desc_dpl != cpl);
      C_DATA:  priv_bad = !(desc_type[4:3] == 2'b11 && conf) &&
                          ((rpl > desc_dpl) || (cpl > desc_dpl));
      default: priv_bad = 1'b0;
    endcase
  end

  always_comb begin
    f_d = 1'b1;
    v_d = V_TS;
    if (reg_class == C_LDT && ti) v_d = V_TS;
    else if (lim_bad) v_d = V_TS;
    else if (is_null) begin
      if (reg_class == C_CODE || reg_class == C_STACK) v_d = V_TS;
      else begin f_d = 1'b0; v_d = 8'd0; end
    end
    else if (!type_ok) v_d = V_TS;
    else if (!desc_present)
      v_d = (reg_class == C_LDT) ? V_TS : (reg_class == C_STACK) ? V_SS : V_NP;
    else if (priv_bad) v_d = V_TS;
    else begin f_d = 1'b0; v_d = 8'd0; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      fault      <= 1'b0;
      vector     <= 8'd0;
      err_code   <= 16'd0;
      seg_base   <= 32'd0;
      seg_limit  <= 32'd0;
      seg_access <= 17'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fault    <= f_d;
        vector   <= v_d;
        err_code <= f_d ? {selector[15:2], 1'b0, ext} : 16'd0;
        if (f_d) begin
          seg_base   <= 32'd0;
          seg_limit  <= 32'd0;
          seg_access <= 17'd0;
        end else if (is_null) begin
          seg_base   <= 32'd0;
          seg_limit  <= 32'd0;
          seg_access <= 17'h10000;
        end else begin
          seg_base   <= desc_base;
          seg_limit  <= desc_gran ? {desc_limit, 12'hFFF} : {12'd0, desc_limit};
          seg_access <= {1'b0, desc_gran, desc_db, 1'b0, desc_avl, 4'd0,
                         desc_present, desc_dpl, desc_type};
        end
      end
    end
  end
endmodule

// File: rtl/seg_load_check_sva.sv
module seg_load_check_sva #(
  parameter int LW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    reg_class,
  input logic [15:0]   selector,
  input logic [1:0]    cpl,
  input logic [LW-1:0] gdt_limit,
  input logic [LW-1:0] ldt_limit,
  input logic          ldt_ok,
  input logic [4:0]    desc_type,
  input logic [1:0]    desc_dpl,
  input logic          desc_present,
  input logic          desc_avl,
  input logic          desc_db,
  input logic          desc_gran,
  input logic [19:0]   desc_limit,
  input logic [31:0]   desc_base,
  input logic          ext,
  input logic          out_valid,
  input logic          fault,
  input logic [7:0]    vector,
  input logic [15:0]   err_code,
  input logic [31:0]   seg_base,
  input logic [31:0]   seg_limit,
  input logic [16:0]   seg_access
);
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_vec_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault) |-> (vector >= 8'd10 && vector <= 8'd12));
  p_ss_only_stack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && reg_class != 2'd2) |=> !(fault && vector == 8'd12));
  p_errcode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (fault ? (err_code == {$past(selector[15:2]), 1'b0, $past(ext)})
                        : (err_code == 16'd0 && vector == 8'd0)));
  p_unusable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fault && seg_access[16]) |-> (seg_base == 32'd0 && seg_limit == 32'd0));
  p_gran_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fault && seg_access[15]) |-> (seg_limit[11:0] == 12'hFFF));
endmodule

bind seg_load_check seg_load_check_sva #(.LW(LW)) ck (.*);

// File: tb/seg_load_check_test.sv
module seg_load_check_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] reg_class = 0, cpl = 0, desc_dpl = 0;
  logic [15:0] selector = 0;
  logic [31:0] gdt_limit = 0, ldt_limit = 0, desc_base = 0;
  logic ldt_ok = 0, desc_present = 0, desc_avl = 0, desc_db = 0, desc_gran = 0, ext = 0;
  logic [4:0] desc_type = 0;
  logic [19:0] desc_limit = 0;
  logic out_valid, fault;
  logic [7:0] vector;
  logic [15:0] err_code;
  logic [31:0] seg_base, seg_limit;
  logic [16:0] seg_access;

  typedef struct {
    logic f; logic [7:0] v; logic [15:0] e;
    logic [31:0] b; logic [31:0] l; logic [16:0] a; string tag;
  } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_load_check uut (.*);

  function automatic logic [16:0] acc_of();
    return {1'b0, desc_gran, desc_db, 1'b0, desc_avl, 4'd0, desc_present, desc_dpl, desc_type};
  endfunction

  task automatic defaults();
    reg_class = 2'd1; selector = 16'h0008; cpl = 0;
    gdt_limit = 32'hFFFF; ldt_limit = 32'hFFFF; ldt_ok = 1;
    desc_type = 5'h1A; desc_dpl = 0; desc_present = 1; desc_avl = 0;
    desc_db = 1; desc_gran = 0; desc_limit = 20'h12345; desc_base = 32'hDEAD0000; ext = 0;
  endtask

  task automatic send_fault(input logic [7:0] v, input string tag);
    exp_t x;
    @(negedge clk);
    x.f = 1; x.v = v; x.e = {selector[15:2], 1'b0, ext};
    x.b = 0; x.l = 0; x.a = 0; x.tag = tag;
    q.push_back(x);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_pass(input logic [31:0] b, input logic [31:0] l,
                           input logic [16:0] a, input string tag);
    exp_t x;
    @(negedge clk);
    x.f = 0; x.v = 0; x.e = 0; x.b = b; x.l = l; x.a = a; x.tag = tag;
    q.push_back(x);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t x;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected out_valid, expected none");
      end else begin
        x = q.pop_front();
        if (fault !== x.f || vector !== x.v || err_code !== x.e ||
            seg_base !== x.b || seg_limit !== x.l || seg_access !== x.a) begin
          errors++;
          $display("FAIL %s: got f=%0b v=%0d e=%h b=%h l=%h a=%h exp f=%0b v=%0d e=%h b=%h l=%h a=%h",
                   x.tag, fault, vector, err_code, seg_base, seg_limit, seg_access,
                   x.f, x.v, x.e, x.b, x.l, x.a);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || fault !== 0 || seg_access !== 0) begin
      errors++;
      $display("FAIL R1 reset state: ov=%0b f=%0b a=%h expected 0", out_valid, fault, seg_access);
    end
    rst_n = 1;

    // R12 R1 code pass
    defaults(); send_pass(32'hDEAD0000, 32'h12345, acc_of(), "R12 code pass");
    // R11 R12 granular data with AVL
    defaults(); reg_class = 3; selector = 16'h0010; desc_type = 5'h13; desc_dpl = 3;
    desc_gran = 1; desc_avl = 1;
    send_pass(32'hDEAD0000, 32'h12345FFF, 17'h0D0F3, "R11 granular limit");
    // R2
    defaults(); reg_class = 0; selector = 16'h000C; desc_type = 5'h02; ext = 1;
    send_fault(10, "R2 local-table via TI");
    // R3 limit boundary
    defaults(); selector = 16'h0040; gdt_limit = 32'h3F; send_fault(10, "R3 over limit");
    defaults(); selector = 16'h0040; gdt_limit = 32'h47;
    send_pass(32'hDEAD0000, 32'h12345, acc_of(), "R3 at limit");
    defaults(); reg_class = 3; selector = 16'h000C; desc_type = 5'h13; ldt_ok = 0;
    send_fault(10, "R3 local table unusable");
    defaults(); reg_class = 3; selector = 16'h000C; desc_type = 5'h13; ldt_limit = 32'h8;
    send_fault(10, "R3 local limit");
    // R4 null
    defaults(); selector = 16'h0003; send_fault(10, "R4 null code");
    defaults(); reg_class = 2; selector = 16'h0000; desc_type = 5'h12; send_fault(10, "R4 null stack");
    defaults(); reg_class = 3; selector = 16'h0002; send_pass(0, 0, 17'h10000, "R4 null data");
    defaults(); reg_class = 0; selector = 16'h0000; send_pass(0, 0, 17'h10000, "R4 null local-table");
    // R5 types
    defaults(); reg_class = 2; selector = 16'h0018; desc_type = 5'h10; send_fault(10, "R5 stack read-only");
    defaults(); reg_class = 2; selector = 16'h0018; desc_type = 5'h12;
    send_pass(32'hDEAD0000, 32'h12345, 17'h04092, "R5 stack ok");
    defaults(); reg_class = 0; desc_type = 5'h02;
    send_pass(32'hDEAD0000, 32'h12345, 17'h04082, "R5 local-table ok");
    defaults(); reg_class = 0; desc_type = 5'h1A; send_fault(10, "R5 local-table wrong type");
    defaults(); reg_class = 3; desc_type = 5'h18; send_fault(10, "R5 data exec-only");
    defaults(); desc_type = 5'h12; send_fault(10, "R5 code from data type");
    // R6 not present
    defaults(); reg_class = 0; desc_type = 5'h02; desc_present = 0; send_fault(10, "R6 local-table absent");
    defaults(); reg_class = 2; desc_type = 5'h12; desc_present = 0; send_fault(12, "R6 stack absent");
    defaults(); desc_present = 0; send_fault(11, "R6 code absent");
    defaults(); reg_class = 3; desc_type = 5'h13; desc_present = 0; send_fault(11, "R6 data absent");
    // R7
    defaults(); reg_class = 2; selector = 16'h001B; cpl = 3; desc_type = 5'h12; desc_dpl = 2;
    send_fault(10, "R7 stack dpl");
    defaults(); reg_class = 2; selector = 16'h0019; cpl = 3; desc_type = 5'h12; desc_dpl = 3;
    send_fault(10, "R7 stack rpl");
    defaults(); reg_class = 2; selector = 16'h001B; cpl = 3; desc_type = 5'h12; desc_dpl = 3;
    send_pass(32'hDEAD0000, 32'h12345, 17'h040F2, "R7 stack ok");
    // R8
    defaults(); desc_type = 5'h1E; desc_dpl = 2; cpl = 1; send_fault(10, "R8 conforming cpl<dpl");
    defaults(); desc_type = 5'h1E; desc_dpl = 2; cpl = 3;
    send_pass(32'hDEAD0000, 32'h12345, 17'h040DE, "R8 conforming ok");
    defaults(); desc_dpl = 0; cpl = 3; send_fault(10, "R8 nonconforming mismatch");
    // R9
    defaults(); reg_class = 3; selector = 16'h0012; desc_type = 5'h13; desc_dpl = 1;
    send_fault(10, "R9 data rpl>dpl");
    defaults(); reg_class = 3; cpl = 2; desc_type = 5'h13; desc_dpl = 1;
    send_fault(10, "R9 data cpl>dpl");
    defaults(); reg_class = 3; selector = 16'h000B; cpl = 3; desc_type = 5'h1E; desc_dpl = 0;
    send_pass(32'hDEAD0000, 32'h12345, 17'h0409E, "R9 conforming code as data");
    // R10 ext flag and TI kept in error code
    defaults(); reg_class = 3; selector = 16'h00AF; desc_type = 5'h13; desc_dpl = 0; ext = 1;
    send_fault(10, "R10 error code");
    // R13 ordering
    defaults(); reg_class = 2; selector = 16'h0018; desc_type = 5'h10; desc_present = 0;
    send_fault(10, "R13 type before present");
    defaults(); reg_class = 3; cpl = 3; desc_type = 5'h13; desc_dpl = 0; desc_present = 0;
    send_fault(11, "R13 present before privilege");
    defaults(); reg_class = 2; selector = 16'h0000; gdt_limit = 0; desc_type = 5'h12;
    send_fault(10, "R13 limit before null");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 %0d results missing, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule